// File: doc/BRIEF.md
# Shared-Line Interrupt Routing Unit

This unit gathers seven level-sensitive interrupt inputs, latches each one into a readable status bit and steers it to one of six output request lines through six 64-bit routing entries. Every routing entry carries a target server number, a priority and a source number. The source number selects which output line the entry drives. The first two inputs are merged into a single entry and a single line. The other five inputs each own an entry. Software reads and writes the entries through a simple single-cycle register port. A downstream presenter consumes the lines together with the effective server and priority of each entry.

Each entry runs a two-state machine. `ENT_QUIET` means no input of the entry is high. `ENT_RAISED` means at least one of them is high. The transition `QUIET->RAISED` fires on the edge at which any input of the entry is sampled high. The transition `RAISED->QUIET` fires only when every input of the entry is sampled low. For the merged entry this means that both inputs must be low. Each entry also keeps a pending flag that reports whether it is asserted and unmasked. The flag is re-evaluated when an input of the entry changes and when software writes the entry. A priority of all ones means masked.

Register indices on the port: 0x0E holds the merged-input status, 0x15 holds the status of the other inputs, 0x10 is the merged entry and 0x16 to 0x1A are entries 1 to 5 in order. Every other index reads as all ones.

Top module: `shared_irq_router`

## Requirements
- R1: After reset, every entry reads with priority 0xFF (bits 39:32), its own index 0..5 as source (bits 31:29), server 0 and pending 0. All lines, the error flag and the effective-server outputs are low.
- R2: One clock after an input changes, its status bit follows it. Inputs 0 and 1 appear at bits 47 and 46 of index 0x0E. Inputs 2 to 6 appear at bits 36 down to 32 of index 0x15. All other bits of both registers read 0.
- R3: One clock after an input rises, the output line numbered by its entry's source field is high, whether or not the entry is masked. The line falls one clock after the entry returns to `ENT_QUIET`.
- R4: The merged entry (inputs 0 and 1) stays in `ENT_RAISED`, and its line stays high, until both inputs are low.
- R5: When an input of an entry changes, the pending flag (bit 24) becomes 1 if the entry is still raised and its priority is not 0xFF, and 0 otherwise.
- R6: A write to an entry stores only server (55:40), priority (39:32) and source (31:29). Every other written bit is ignored, and the pending flag keeps its value unless R7 applies.
- R7: A write that sets priority 0xFF clears the pending flag on the next clock.
- R8: For each entry, the effective-server output equals the stored server field shifted right by 2, and the priority output equals the stored priority.
- R9: An entry whose source field is 6 or 7 raises `src_err` and drives no line.
- R10: The lines always follow the current source fields, so rewriting the source of a raised entry moves its request to the new line on the next clock.
- R11: Writes to indices 0x0E and 0x15 leave them unchanged, and reads of unmapped indices return all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 7 | Level interrupt inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| irq_line | output | 6 | Request line per source number |
| src_err | output | 1 | Some entry holds a source number with no line |
| route_server | output | 84 | Effective server per entry, 14 bits each, entry 0 lowest |
| route_prio | output | 48 | Priority per entry, 8 bits each, entry 0 lowest |

## Verification
A state machine stuck in `ENT_RAISED`, or released too early, shows up one clock later as a wrong level on `irq_line`. In the merged case this is visible when only one of inputs 0 and 1 falls. A stale pending flag appears at bit 24 on the very next read of the entry, so the tests read the entry right after each input change and each priority write. A source field that decodes to the wrong line, or an out-of-range value that leaks through, is seen on `irq_line` and `src_err` in the same cycle that the entry is written.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int DATA_W   = 64;
    localparam int SRV_W    = 16;
    localparam int PRIO_W   = 8;
    localparam int SRC_W    = 3;
    localparam int LINK_W   = 2;
    localparam int EFF_W    = SRV_W - LINK_W;

    localparam int SRV_LSB  = 40;
    localparam int PRIO_LSB = 32;
    localparam int SRC_LSB  = 29;
    localparam int PEND_BIT = 24;

    typedef enum logic {
        ENT_QUIET  = 1'b0,
        ENT_RAISED = 1'b1
    } ent_state_t;

    typedef struct packed {
        logic [SRV_W-1:0]  server;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  src;
        logic              pend;
    } route_t;

    function automatic logic [DATA_W-1:0] pack_route(route_t r);
        logic [DATA_W-1:0] v;
        v = '0;
        v[SRV_LSB  +: SRV_W]  = r.server;
        v[PRIO_LSB +: PRIO_W] = r.prio;
        v[SRC_LSB  +: SRC_W]  = r.src;
        v[PEND_BIT]           = r.pend;
        return v;
    endfunction

endpackage

// File: rtl/sirq_capture.sv
module sirq_capture #(
    parameter int NUM_IN = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] irq_in,
    output logic [NUM_IN-1:0] status_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= irq_in;
        end
    end

endmodule

// File: rtl/sirq_route_entry.sv
module sirq_route_entry
    import sirq_pkg::*;
#(
    parameter int               IN_N      = 1,
    parameter logic [SRC_W-1:0] RESET_SRC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_N-1:0]   in_now,
    input  logic [IN_N-1:0]   in_q,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output route_t            cfg,
    output logic              raised
);

    localparam logic [PRIO_W-1:0] MASK_PRIO = '1;

    ent_state_t state, state_n;
    route_t     cfg_n;
    logic       changed;
    logic       masked_new;
    logic       pend_calc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ENT_QUIET;
            cfg.server <= '0;
            cfg.prio   <= MASK_PRIO;
            cfg.src    <= RESET_SRC;
            cfg.pend   <= 1'b0;
        end else begin
            state <= state_n;
            cfg   <= cfg_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ENT_QUIET:  if (|in_now)  state_n = ENT_RAISED;
            ENT_RAISED: if (!(|in_now)) state_n = ENT_QUIET;
            default:    state_n = ENT_QUIET;
        endcase
    end

    // outputs and configuration update
    always_comb begin
        changed    = (in_now != in_q);
        masked_new = wr_en ? (wr_data[PRIO_LSB +: PRIO_W] == MASK_PRIO)
                           : (cfg.prio == MASK_PRIO);
        cfg_n      = cfg;
        if (wr_en) begin
            cfg_n.server = wr_data[SRV_LSB  +: SRV_W];
            cfg_n.prio   = wr_data[PRIO_LSB +: PRIO_W];
            cfg_n.src    = wr_data[SRC_LSB  +: SRC_W];
        end
        if (changed) begin
            pend_calc = (state_n == ENT_RAISED) && !masked_new;
        end else begin
            pend_calc = cfg.pend && !masked_new;
        end
        cfg_n.pend = pend_calc;
        raised     = (state == ENT_RAISED);
    end

    assert_state_tracks_inputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENT_RAISED) == (|in_q));

    assert_pend_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.pend |-> (cfg.prio != MASK_PRIO));

    assert_pend_needs_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.pend |-> (state == ENT_RAISED));

    assert_mask_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[PRIO_LSB +: PRIO_W] == MASK_PRIO) |=> !cfg.pend);

    assert_write_keeps_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg.src == $past(wr_data[SRC_LSB +: SRC_W])));

endmodule

// File: rtl/sirq_line_mux.sv
module sirq_line_mux
    import sirq_pkg::*;
#(
    parameter int NUM_ENT   = 6,
    parameter int NUM_LINES = 6
) (
    input  logic [NUM_ENT-1:0]       raised,
    input  logic [NUM_ENT*SRC_W-1:0] src_flat,
    output logic [NUM_LINES-1:0]     line,
    output logic                     cfg_err
);

    always_comb begin
        line    = '0;
        cfg_err = 1'b0;
        for (int e = 0; e < NUM_ENT; e++) begin
            if (32'(src_flat[e*SRC_W +: SRC_W]) >= NUM_LINES) begin
                cfg_err = 1'b1;
            end
            for (int s = 0; s < NUM_LINES; s++) begin
                if (raised[e] && src_flat[e*SRC_W +: SRC_W] == SRC_W'(s)) begin
                    line[s] = 1'b1;
                end
            end
        end
    end

    always_comb begin
        assert_lines_need_raise_R3: assert ((|raised) || (line == '0));
    end

endmodule

// File: rtl/shared_irq_router.sv
module shared_irq_router
    import sirq_pkg::*;
#(
    parameter int NUM_ENT   = 6,
    parameter int NUM_LINES = 6,
    parameter int NUM_IN    = NUM_ENT + 1,
    parameter int ADDR_W    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN-1:0]        irq_in,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    output logic [NUM_LINES-1:0]     irq_line,
    output logic                     src_err,
    output logic [NUM_ENT*EFF_W-1:0] route_server,
    output logic [NUM_ENT*PRIO_W-1:0] route_prio
);

    localparam int CTRL_ADDR   = 'h0E;
    localparam int STAT_ADDR   = 'h15;
    localparam int SHARED_ADDR = 'h10;
    localparam int FIRST_ADDR  = 'h16;
    localparam int CTRL_HI     = 47;
    localparam int STAT_HI     = 36;
    localparam int SHARED_N    = 2;

    function automatic logic [ADDR_W-1:0] ent_addr(int e);
        return (e == 0) ? ADDR_W'(SHARED_ADDR) : ADDR_W'(FIRST_ADDR + e - 1);
    endfunction

    logic [NUM_IN-1:0]        status_q;
    route_t                   cfg_arr [NUM_ENT];
    logic [NUM_ENT-1:0]       raised;
    logic [NUM_ENT-1:0]       ent_we;
    logic [NUM_ENT*SRC_W-1:0] src_flat;

    sirq_capture #(.NUM_IN(NUM_IN)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_in),
        .status_q (status_q)
    );

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        assign ent_we[e] = reg_we && (reg_addr == ent_addr(e));
        assign src_flat[e*SRC_W +: SRC_W]       = cfg_arr[e].src;
        assign route_server[e*EFF_W +: EFF_W]   = cfg_arr[e].server[SRV_W-1:LINK_W];
        assign route_prio[e*PRIO_W +: PRIO_W]   = cfg_arr[e].prio;

        if (e == 0) begin : g_shared
            sirq_route_entry #(.IN_N(SHARED_N), .RESET_SRC(SRC_W'(e))) u_ent (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_now  (irq_in[SHARED_N-1:0]),
                .in_q    (status_q[SHARED_N-1:0]),
                .wr_en   (ent_we[e]),
                .wr_data (reg_wdata),
                .cfg     (cfg_arr[e]),
                .raised  (raised[e])
            );
        end else begin : g_single
            sirq_route_entry #(.IN_N(1), .RESET_SRC(SRC_W'(e))) u_ent (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_now  (irq_in[e+1]),
                .in_q    (status_q[e+1]),
                .wr_en   (ent_we[e]),
                .wr_data (reg_wdata),
                .cfg     (cfg_arr[e]),
                .raised  (raised[e])
            );
        end
    end

    sirq_line_mux #(.NUM_ENT(NUM_ENT), .NUM_LINES(NUM_LINES)) u_mux (
        .raised   (raised),
        .src_flat (src_flat),
        .line     (irq_line),
        .cfg_err  (src_err)
    );

    always_comb begin
        reg_rdata = '1;
        if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
            reg_rdata = '0;
            for (int i = 0; i < SHARED_N; i++) begin
                reg_rdata[CTRL_HI-i] = status_q[i];
            end
        end
        if (reg_addr == ADDR_W'(STAT_ADDR)) begin
            reg_rdata = '0;
            for (int k = SHARED_N; k < NUM_IN; k++) begin
                reg_rdata[STAT_HI-(k-SHARED_N)] = status_q[k];
            end
        end
        for (int e = 0; e < NUM_ENT; e++) begin
            if (reg_addr == ent_addr(e)) begin
                reg_rdata = pack_route(cfg_arr[e]);
            end
        end
    end

endmodule

// File: tb/sim_shared_irq_router.sv
`timescale 1ns/1ps
module sim_shared_irq_router;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [6:0]   irq_in;
    logic         reg_we;
    logic [4:0]   reg_addr;
    logic [63:0]  reg_wdata;
    logic [63:0]  reg_rdata;
    logic [5:0]   irq_line;
    logic         src_err;
    logic [83:0]  route_server;
    logic [47:0]  route_prio;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    shared_irq_router u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_line     (irq_line),
        .src_err      (src_err),
        .route_server (route_server),
        .route_prio   (route_prio)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(5'h10, v); chk("R1 entry0", v, 64'h000000FF00000000);
        rd(5'h16, v); chk("R1 entry1", v, 64'h000000FF20000000);
        rd(5'h1a, v); chk("R1 entry5", v, 64'h000000FFA0000000);
        chk("R1 lines", 64'(irq_line), 64'h0);
        chk("R1 err", 64'(src_err), 64'h0);
        chk("R1 server", 64'(route_server[63:0]), 64'h0);
    endtask

    task automatic t_status_and_line();
        logic [63:0] v;
        irq_in[3] = 1'b1; tick();
        rd(5'h15, v); chk("R2 status bit35", v, 64'h0000000800000000);
        chk("R3 line2 masked", 64'(irq_line), 64'h04);
        rd(5'h17, v); chk("R5 masked no pend", v, 64'h000000FF40000000);
        irq_in[3] = 1'b0; tick();
        chk("R3 line2 low", 64'(irq_line), 64'h0);
        irq_in[2] = 1'b1; irq_in[6] = 1'b1; tick();
        rd(5'h15, v); chk("R2 status bits36_32", v, 64'h0000001100000000);
        chk("R3 lines1_5", 64'(irq_line), 64'h22);
        irq_in[2] = 1'b0; irq_in[6] = 1'b0; tick();
        rd(5'h15, v); chk("R2 status clear", v, 64'h0);
    endtask

    task automatic t_pending();
        logic [63:0] v;
        wr(5'h17, 64'h8001240541000001);
        rd(5'h17, v); chk("R6 fields only", v, 64'h0001240540000000);
        chk("R8 eff server", 64'(route_server[2*14 +: 14]), 64'h49);
        chk("R8 prio", 64'(route_prio[2*8 +: 8]), 64'h05);
        irq_in[3] = 1'b1; tick();
        rd(5'h17, v); chk("R5 pend set", v, 64'h0001240541000000);
        wr(5'h17, 64'h0001240640000000);
        rd(5'h17, v); chk("R6 pend kept", v, 64'h0001240641000000);
        wr(5'h17, 64'h000124FF40000000);
        rd(5'h17, v); chk("R7 pend cleared", v, 64'h000124FF40000000);
        chk("R3 line stays when masked", 64'(irq_line), 64'h04);
        wr(5'h17, 64'h0001240540000000);
        rd(5'h17, v); chk("R6 unmask no pend", v, 64'h0001240540000000);
        irq_in[3] = 1'b0; tick();
        rd(5'h17, v); chk("R5 pend on fall", v, 64'h0001240540000000);
        chk("R3 line2 off", 64'(irq_line), 64'h0);
    endtask

    task automatic t_shared();
        logic [63:0] v;
        wr(5'h10, 64'h0000000300000000);
        irq_in[0] = 1'b1; tick();
        rd(5'h10, v); chk("R5 shared pend", v, 64'h0000000301000000);
        chk("R3 line0", 64'(irq_line), 64'h01);
        irq_in[1] = 1'b1; tick();
        rd(5'h0e, v); chk("R2 ctrl both", v, 64'h0000C00000000000);
        irq_in[0] = 1'b0; tick();
        rd(5'h0e, v); chk("R2 ctrl in1", v, 64'h0000400000000000);
        chk("R4 line0 held", 64'(irq_line), 64'h01);
        rd(5'h10, v); chk("R4 pend held", v, 64'h0000000301000000);
        irq_in[1] = 1'b0; tick();
        chk("R4 line0 released", 64'(irq_line), 64'h0);
        rd(5'h10, v); chk("R4 pend released", v, 64'h0000000300000000);
    endtask

    task automatic t_bad_src();
        wr(5'h18, 64'h000000FFE0000000);
        chk("R9 err", 64'(src_err), 64'h1);
        irq_in[4] = 1'b1; tick();
        chk("R9 no line", 64'(irq_line), 64'h0);
        wr(5'h18, 64'h000000FF60000000);
        chk("R9 err gone", 64'(src_err), 64'h0);
        chk("R10 line3", 64'(irq_line), 64'h08);
        wr(5'h18, 64'h000000FF20000000);
        chk("R10 moved to line1", 64'(irq_line), 64'h02);
        irq_in[4] = 1'b0; tick();
        chk("R10 off", 64'(irq_line), 64'h0);
    endtask

    task automatic t_readonly();
        logic [63:0] v;
        wr(5'h15, 64'hFFFFFFFFFFFFFFFF);
        wr(5'h0e, 64'hFFFFFFFFFFFFFFFF);
        rd(5'h15, v); chk("R11 status ro", v, 64'h0);
        rd(5'h0e, v); chk("R11 ctrl ro", v, 64'h0);
        rd(5'h16, v); chk("R11 entry1 intact", v, 64'h000000FF20000000);
        rd(5'h00, v); chk("R11 unmapped 00", v, 64'hFFFFFFFFFFFFFFFF);
        rd(5'h11, v); chk("R11 unmapped 11", v, 64'hFFFFFFFFFFFFFFFF);
        rd(5'h1b, v); chk("R11 unmapped 1b", v, 64'hFFFFFFFFFFFFFFFF);
    endtask

    initial begin
        rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_status_and_line();
        t_pending();
        t_shared();
        t_bad_src();
        t_readonly();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule